// File: doc/BRIEF.md
# ALU Operation Selector for a 32-bit RISC-V Core

This block is a purely combinational selector. It sits between the main instruction decoder and the ALU of a 32-bit RISC-V core. It takes a 2-bit mode hint from the control path, a flag for immediate-form instructions, and the two function fields of the instruction word (7 bits and 3 bits). From these it produces the 4-bit code that tells the ALU what to compute.

There are three working modes:

- **Register-register mode** decodes both function fields fully. It rejects any upper-field pattern that is not legal.
- **Address mode** always asks for an addition. Loads and stores use it to form addresses.
- **Immediate mode** lets the 3-bit field alone pick the operation. The one exception is the right-shift case, where bit 5 of the upper field still chooses between the arithmetic and logical shift.

Any input that matches no rule gives the all-ones code, which means invalid.

Top module: `alu_ctl_dec`

## Requirements
- R1: The operation codes are: and=0, or=1, add=2, sub=3, sra=4, sltu=5, xor=6, srl=7, slt=8, sll=9. The invalid code is 15 (binary 1111).
- R2: With mode=00 and imm=0, funct3=000 gives add (2) when funct7=0000000 and sub (3) when funct7=0100000.
- R3: With mode=00 and imm=0, funct3=101 gives srl (7) when funct7=0000000 and sra (4) when funct7=0100000.
- R4: With mode=00, imm=0 and funct7=0000000, funct3 selects as follows: 001 gives sll, 010 gives slt, 011 gives sltu, 100 gives xor, 110 gives or, 111 gives and.
- R5: With mode=00 and imm=0, the output is 15 for any other funct7 value. It is also 15 for funct7=0100000 when funct3 is anything other than 000 or 101.
- R6: mode=01 gives add (2) whatever the values of imm, funct7 and funct3.
- R7: With mode=00 and imm=1, funct3 alone selects the operation, using the R4 mapping plus 000 giving add. The exception is funct3=101, where funct7 bit 5 gives sra (1) or srl (0). All other funct7 bits have no effect.
- R8: mode=10 and mode=11 give 15 whatever the other inputs are.
- R9: The output never takes a code from 10 to 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aluop | input | 2 | Mode hint: 00 register-register, 01 forced add, 1x reserved |
| itype | input | 1 | Immediate-form instruction flag |
| funct7 | input | 7 | Upper function field of the instruction |
| funct3 | input | 3 | Middle function field of the instruction |
| operation | output | 4 | ALU operation code |

## Verification
The bench builds the block with its default field widths, which are 2, 1, 7 and 3 bits. These widths are fixed by the instruction format, so the whole input space is only 8192 combinations. The bench therefore sweeps every one of them. This covers each illegal funct7 pattern, every reserved mode, and the immediate shift exception. A seeded random phase and named directed cases then confirm each individual code value.

// File: rtl/alu_ctl_pkg.sv
package alu_ctl_pkg;
  localparam int MODE_W  = 2;
  localparam int F7_W    = 7;
  localparam int F3_W    = 3;
  localparam int OP_W    = 4;
  localparam int ALT_BIT = 5;
  localparam logic [F7_W-1:0] F7_BASE = '0;
  localparam logic [F7_W-1:0] F7_ALT  = F7_W'(1) << ALT_BIT;

  typedef enum logic [OP_W-1:0] {
    OP_AND  = 4'd0,
    OP_OR   = 4'd1,
    OP_ADD  = 4'd2,
    OP_SUB  = 4'd3,
    OP_SRA  = 4'd4,
    OP_SLTU = 4'd5,
    OP_XOR  = 4'd6,
    OP_SRL  = 4'd7,
    OP_SLT  = 4'd8,
    OP_SLL  = 4'd9,
    OP_BAD  = 4'd15
  } op_e;

  typedef enum logic [MODE_W-1:0] {
    MODE_REG  = 2'b00,
    MODE_ADDR = 2'b01,
    MODE_RSV2 = 2'b10,
    MODE_RSV3 = 2'b11
  } mode_e;

  // funct3 to operation, with the alternate flag choosing sub/sra
  function automatic op_e f3_to_op(input logic [F3_W-1:0] f3, input logic alt);
    op_e r;
    case (f3)
      3'b000:  r = alt ? OP_SUB : OP_ADD;
      3'b001:  r = OP_SLL;
      3'b010:  r = OP_SLT;
      3'b011:  r = OP_SLTU;
      3'b100:  r = OP_XOR;
      3'b101:  r = alt ? OP_SRA : OP_SRL;
      3'b110:  r = OP_OR;
      default: r = OP_AND;
    endcase
    return r;
  endfunction

  // funct3 values where the alternate funct7 pattern is legal
  function automatic logic f3_takes_alt(input logic [F3_W-1:0] f3);
    return (f3 == 3'b000) || (f3 == 3'b101);
  endfunction
endpackage

// File: rtl/alu_ctl_f7_class.sv
module alu_ctl_f7_class
  import alu_ctl_pkg::*;
(
  input  logic [F7_W-1:0] funct7,
  output logic            f7_base,
  output logic            f7_alt,
  output logic            f7_alt_bit
);
  assign f7_base    = (funct7 == F7_BASE);
  assign f7_alt     = (funct7 == F7_ALT);
  assign f7_alt_bit = funct7[ALT_BIT];
endmodule

// File: rtl/alu_ctl_reg_dec.sv
module alu_ctl_reg_dec
  import alu_ctl_pkg::*;
(
  input  logic [F3_W-1:0] funct3,
  input  logic            f7_base,
  input  logic            f7_alt,
  output op_e             reg_op
);
  logic alt_ok;
  assign alt_ok = f7_alt && f3_takes_alt(funct3);

  always_comb begin
    if (f7_base)     reg_op = f3_to_op(funct3, 1'b0);
    else if (alt_ok) reg_op = f3_to_op(funct3, 1'b1);
    else             reg_op = OP_BAD;
  end
endmodule

// File: rtl/alu_ctl_imm_dec.sv
module alu_ctl_imm_dec
  import alu_ctl_pkg::*;
(
  input  logic [F3_W-1:0] funct3,
  input  logic            f7_alt_bit,
  output op_e             imm_op
);
  logic shift_alt;
  assign shift_alt = f7_alt_bit && (funct3 == 3'b101);
  assign imm_op    = f3_to_op(funct3, shift_alt);
endmodule

// File: rtl/alu_ctl_dec.sv
module alu_ctl_dec
  import alu_ctl_pkg::*;
(
  input  logic [MODE_W-1:0] aluop,
  input  logic              itype,
  input  logic [F7_W-1:0]   funct7,
  input  logic [F3_W-1:0]   funct3,
  output logic [OP_W-1:0]   operation
);
  logic f7_base, f7_alt, f7_alt_bit;
  op_e  reg_op, imm_op, sel_op;
  mode_e mode;

  assign mode = mode_e'(aluop);

  alu_ctl_f7_class i_class (
    .funct7     (funct7),
    .f7_base    (f7_base),
    .f7_alt     (f7_alt),
    .f7_alt_bit (f7_alt_bit)
  );

  alu_ctl_reg_dec i_reg (
    .funct3  (funct3),
    .f7_base (f7_base),
    .f7_alt  (f7_alt),
    .reg_op  (reg_op)
  );

  alu_ctl_imm_dec i_imm (
    .funct3     (funct3),
    .f7_alt_bit (f7_alt_bit),
    .imm_op     (imm_op)
  );

  always_comb begin
    case (mode)
      MODE_REG:  sel_op = itype ? imm_op : reg_op;
      MODE_ADDR: sel_op = OP_ADD;
      default:   sel_op = OP_BAD;
    endcase
  end

  assign operation = sel_op;
endmodule

// File: rtl/alu_ctl_dec_chk.sv
module alu_ctl_dec_chk
  import alu_ctl_pkg::*;
(
  input logic [MODE_W-1:0] aluop,
  input logic              itype,
  input logic [F7_W-1:0]   funct7,
  input logic [F3_W-1:0]   funct3,
  input logic [OP_W-1:0]   operation,
  input op_e               reg_op,
  input op_e               imm_op
);
  always_comb begin
    if (aluop == 2'b01)
      p_addr_add_r6: assert (operation == 4'd2);
    if (aluop[1])
      p_rsv_bad_r8: assert (operation == 4'd15);
    p_no_gap_code_r9: assert (operation <= 4'd9 || operation == 4'd15);
    if (aluop == 2'b00 && !itype && funct7 != 7'h00 && funct7 != 7'h20)
      p_bad_f7_r5: assert (operation == 4'd15);
    if (aluop == 2'b00 && !itype && funct7 == 7'h20 && funct3 == 3'b000)
      p_sub_r2: assert (operation == 4'd3);
    if (aluop == 2'b00 && !itype && funct7 == 7'h20 && funct3 == 3'b101)
      p_sra_r3: assert (operation == 4'd4);
    if (aluop == 2'b00 && itype)
      p_imm_valid_r7: assert (operation != 4'd15 && operation != 4'd3);
    p_paths_agree_r4: assert (reg_op == OP_BAD || imm_op == reg_op || funct3 == 3'b101
                              || funct3 == 3'b000);
  end
endmodule

bind alu_ctl_dec alu_ctl_dec_chk i_chk (
  .aluop     (aluop),
  .itype     (itype),
  .funct7    (funct7),
  .funct3    (funct3),
  .operation (operation),
  .reg_op    (reg_op),
  .imm_op    (imm_op)
);

// File: tb/test_alu_ctl_dec.sv
`timescale 1ns/1ps
module test_alu_ctl_dec;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] aluop = '0;
  logic       itype = 1'b0;
  logic [6:0] funct7 = '0;
  logic [2:0] funct3 = '0;
  logic [3:0] operation;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  alu_ctl_dec i_alu_ctl_dec (
    .aluop(aluop), .itype(itype), .funct7(funct7), .funct3(funct3), .operation(operation)
  );

  // expected code, written from the requirement text
  function automatic logic [3:0] expect_op(input logic [1:0] m, input logic im,
                                           input logic [6:0] f7, input logic [2:0] f3);
    logic [3:0] tbl [8];
    tbl[0] = 4'd2; tbl[1] = 4'd9; tbl[2] = 4'd8; tbl[3] = 4'd5;
    tbl[4] = 4'd6; tbl[5] = 4'd7; tbl[6] = 4'd1; tbl[7] = 4'd0;
    if (m == 2'b01) return 4'd2;
    if (m != 2'b00) return 4'd15;
    if (im) return (f3 == 3'd5 && f7[5]) ? 4'd4 : tbl[f3];
    if (f7 == 7'd0) return tbl[f3];
    if (f7 == 7'd32 && f3 == 3'd0) return 4'd3;
    if (f7 == 7'd32 && f3 == 3'd5) return 4'd4;
    return 4'd15;
  endfunction

  function automatic string tag_of(input logic [1:0] m, input logic im,
                                   input logic [6:0] f7, input logic [2:0] f3);
    if (m == 2'b01) return "R6";
    if (m != 2'b00) return "R8";
    if (im) return "R7";
    if (f7 != 7'd0 && !(f7 == 7'd32 && (f3 == 3'd0 || f3 == 3'd5))) return "R5";
    if (f3 == 3'd0) return "R2";
    if (f3 == 3'd5) return "R3";
    return "R4";
  endfunction

  task automatic apply_check(input logic [1:0] m, input logic im,
                             input logic [6:0] f7, input logic [2:0] f3, input string tag);
    logic [3:0] e;
    @(negedge clk);
    aluop = m; itype = im; funct7 = f7; funct3 = f3;
    #1;
    e = expect_op(m, im, f7, f3);
    n_checks++;
    if (operation !== e) begin
      n_fail++;
      $display("FAIL %s: m=%b i=%b f7=%h f3=%b got %0d expected %0d", tag, m, im, f7, f3, operation, e);
    end
    n_checks++;
    if (operation inside {[4'd10:4'd14]}) begin
      n_fail++;
      $display("FAIL R9: gap code got %0d expected 0..9 or 15", operation);
    end
  endtask

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset-state inputs all zero: add
    #1;
    n_checks++;
    if (operation !== 4'd2) begin
      n_fail++; $display("FAIL R2: idle got %0d expected 2", operation);
    end
    // R1: each named code value
    apply_check(2'b00, 1'b0, 7'h00, 3'b111, "R1_and");
    apply_check(2'b00, 1'b0, 7'h00, 3'b110, "R1_or");
    apply_check(2'b00, 1'b0, 7'h20, 3'b000, "R1_sub");
    apply_check(2'b00, 1'b0, 7'h20, 3'b101, "R1_sra");
    apply_check(2'b00, 1'b0, 7'h00, 3'b011, "R1_sltu");
    apply_check(2'b00, 1'b0, 7'h00, 3'b010, "R1_slt");
    // R7 corners: funct7 noise ignored, bit 5 picks shift
    apply_check(2'b00, 1'b1, 7'h7f, 3'b000, "R7");
    apply_check(2'b00, 1'b1, 7'h5f, 3'b101, "R7");
    apply_check(2'b00, 1'b1, 7'h20, 3'b101, "R7");
    apply_check(2'b00, 1'b1, 7'h20, 3'b001, "R7");
    // R5 corners
    apply_check(2'b00, 1'b0, 7'h20, 3'b001, "R5");
    apply_check(2'b00, 1'b0, 7'h01, 3'b000, "R5");
    apply_check(2'b00, 1'b0, 7'h60, 3'b101, "R5");
    // R6 / R8 corners
    apply_check(2'b01, 1'b1, 7'h7f, 3'b101, "R6");
    apply_check(2'b10, 1'b0, 7'h00, 3'b000, "R8");
    apply_check(2'b11, 1'b1, 7'h00, 3'b000, "R8");
    // exhaustive sweep
    for (int m = 0; m < 4; m++)
      for (int im = 0; im < 2; im++)
        for (int f7 = 0; f7 < 128; f7++)
          for (int f3 = 0; f3 < 8; f3++)
            apply_check(2'(m), 1'(im), 7'(f7), 3'(f3),
                        tag_of(2'(m), 1'(im), 7'(f7), 3'(f3)));
    // seeded random, biased toward legal funct7 values
    for (int k = 0; k < 1000; k++) begin
      logic [1:0] m; logic im; logic [6:0] f7; logic [2:0] f3;
      m  = ($urandom % 4 == 0) ? 2'($urandom) : 2'b00;
      im = 1'($urandom);
      f3 = 3'($urandom);
      case ($urandom % 3)
        0: f7 = 7'h00;
        1: f7 = 7'h20;
        default: f7 = 7'($urandom);
      endcase
      apply_check(m, im, f7, f3, tag_of(m, im, f7, f3));
    end
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule